// File: doc/BRIEF.md
# DMA Sector Progress Tracker

This block follows an IDE-style DMA command while its data arrives as a series of scatter-gather descriptors. It does not move data. It keeps the disk position and the amount of work left, and it decides for each descriptor what request to send to the medium. After every completed request it decides three things: whether the command is finished, whether the current descriptor is used up, and whether the transfer must stop on an error.

Two addressing modes are supported. In disk mode the position is a 512-byte sector number and the count is in sectors; a partial sector counts as a whole one. In packet mode the position is a 2048-byte block plus a byte offset inside that block, and the count is in bytes. The sector sent to the medium is then derived from the block and the offset. Command completion (interrupt plus status) is reported apart from descriptor exhaustion (a DMA-end strobe). A command can therefore finish in the middle of a descriptor list, or a descriptor list can run out while the command is still open.

Each descriptor goes through a fixed pass. Loading the descriptor starts a pass with a previous chunk size of zero. That pass issues one request covering the whole descriptor. The completion of that request starts a second pass, which advances the position and then ends the descriptor.

Top module: `dma_sector_tracker`

## Requirements
- R1: After reset, status is 3'b001 (bit 0 ready, bit 1 seek done, bit 2 error), err_kind is 0, and req_valid, irq and dma_end are low.
- R2: cmd_start, accepted while no request is outstanding, clears status to 3'b000 and err_kind to 0, and latches the mode and the start position. The start position is the sector in disk mode and the block in packet mode. In packet mode the byte offset starts at 0.
- R3: In disk mode a completed chunk of B bytes adds ceil(B/512) to the sector number and takes the same amount off the sector count. The count stops at 0 and never goes below it. Disk mode uses the low 16 bits of cmd_count.
- R4: The first pass that finds the command finished raises irq for one cycle and sets status to 3'b011. The command is finished when the disk count is 0, or when the packet byte count is at or below 0. Later passes of the same command raise no further irq.
- R5: A pass that finds the descriptor length at zero pulses dma_end for one cycle and issues no request. This applies to a pass started by a zero-length descriptor and to every pass started by chunk_done. The dma_end pulse appears two clock edges after the chunk_done or desc_load edge.
- R6: A descriptor of nonzero length produces one request two edges after desc_load. The request carries req_addr equal to the descriptor address, req_len equal to the whole descriptor length, and req_sector equal to the current position. The first pass of a descriptor does not advance the position.
- R7: In packet mode a completed chunk adds its size to the byte offset. The block then grows by offset>>11 and the offset keeps its low 11 bits. req_sector is block*4 + (offset>>9).
- R8: In packet mode each completed chunk takes its size off the byte count, and the count may go below zero. Completion (R4) holds once the count is at or below 0.
- R9: chunk_err while a request is outstanding pulses dma_end one edge later. It sets status to 3'b101 and err_kind to 1 in disk mode or to 2 in packet mode, and it ends the command. After that, desc_load causes no request and no dma_end.
- R10: In packet mode, media_absent high during a pass that would issue a request suppresses the request. dma_end pulses, status becomes 3'b101, err_kind becomes 3, and the command ends.
- R11: req_write equals cmd_write as latched at cmd_start, and is always 0 in packet mode. Changing cmd_write during the command has no effect on later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start a new command |
| cmd_packet | input | 1 | 1 selects packet mode, 0 disk mode |
| cmd_write | input | 1 | Disk direction, 1 for write |
| cmd_lba | input | 28 | Start sector (disk) or start block (packet, low 26 bits) |
| cmd_count | input | 24 | Sector count (disk, low 16 bits) or byte count (packet) |
| desc_load | input | 1 | A new descriptor is present |
| desc_addr | input | 32 | Descriptor memory address |
| desc_len | input | 16 | Descriptor length in bytes |
| chunk_done | input | 1 | Outstanding request completed |
| chunk_err | input | 1 | Outstanding request failed |
| media_absent | input | 1 | Medium refuses packet-mode requests |
| req_valid | output | 1 | One-cycle request strobe |
| req_sector | output | 28 | Request start sector (512-byte units) |
| req_len | output | 16 | Request length in bytes |
| req_addr | output | 32 | Request memory address |
| req_write | output | 1 | Request direction |
| irq | output | 1 | One-cycle command-complete interrupt |
| status | output | 3 | {error, seek done, ready} |
| err_kind | output | 2 | 0 none, 1 DMA error, 2 I/O error, 3 medium absent |
| dma_end | output | 1 | One-cycle descriptor-end strobe |

## Verification
A wrong sector or offset register shows up at the next descriptor's request. Because the first pass of each descriptor issues at the current position without advancing it, req_sector carries the accumulated rounding and offset carry unchanged, two edges after desc_load. A wrong remaining count shows up as an irq that comes one descriptor too early, comes too late, or comes twice. A wrong state or a wrong error path shows up as a missing or misplaced dma_end, or as a request that was not suppressed. The bench predicts every request field, every pulse and the status on each pass, with a bench model over random chunk sizes in both modes. Directed cases add exact multiples, single-byte overruns, count saturation and offset carries.

// File: rtl/dsp_pkg.sv
// Shared types for the DMA sector progress tracker.
// Assumes: one command active at a time; one outstanding request at most.
package dsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAITD = 2'd1,
        ST_PASS  = 2'd2,
        ST_BUSY  = 2'd3
    } trk_state_e;

    typedef enum logic [1:0] {
        ERK_NONE  = 2'd0,
        ERK_DMA   = 2'd1,
        ERK_IO    = 2'd2,
        ERK_NOMED = 2'd3
    } err_kind_e;

    localparam logic [2:0] STAT_RESET = 3'b001;
    localparam logic [2:0] STAT_BUSY  = 3'b000;
    localparam logic [2:0] STAT_DONE  = 3'b011;
    localparam logic [2:0] STAT_FAIL  = 3'b101;
endpackage

// File: rtl/dsp_disk_pos.sv
// Disk-mode position keeper: sector number and remaining sector count.
// A step of B bytes moves both by ceil(B/SECT_BYTES). The count saturates at 0.
// Assumes: ceil(max length / SECT_BYTES) fits in CNT_W bits.
module dsp_disk_pos #(
    parameter int LBA_W      = 28,
    parameter int CNT_W      = 16,
    parameter int LEN_W      = 16,
    parameter int SECT_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [LBA_W-1:0] init_lba,
    input  logic [CNT_W-1:0] init_cnt,
    input  logic             step,
    input  logic [LEN_W-1:0] step_bytes,
    output logic [LBA_W-1:0] lba_nx,
    output logic             zero_nx
);
    localparam int SH = $clog2(SECT_BYTES);

    logic [LBA_W-1:0] lba_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W:0]   rnd_sum;
    logic [CNT_W-1:0] n_sect;
    logic [CNT_W-1:0] cnt_nx;

    // Round the chunk size up to whole sectors and compute the next position.
    always_comb begin
        rnd_sum = (LEN_W+1)'(step_bytes) + (LEN_W+1)'(SECT_BYTES - 1);
        n_sect  = CNT_W'(rnd_sum >> SH);
        lba_nx  = lba_q + LBA_W'(n_sect);
        cnt_nx  = (cnt_q > n_sect) ? (cnt_q - n_sect) : '0;
        zero_nx = (cnt_nx == '0);
    end

    // Hold the sector and the count; load them at command start, advance them per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba_q <= '0;
            cnt_q <= '0;
        end else if (init) begin
            lba_q <= init_lba;
            cnt_q <= init_cnt;
        end else if (step) begin
            lba_q <= lba_nx;
            cnt_q <= cnt_nx;
        end
    end

    // R3
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init) |=> (cnt_q <= $past(cnt_q)));

    // R3
    lba_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && step_bytes != '0) |=> (lba_q != $past(lba_q)));
endmodule

// File: rtl/dsp_pkt_pos.sv
// Packet-mode position keeper: block address, byte offset inside the block,
// and a signed remaining byte count. The medium sector is block*ratio + offset/SECT_BYTES.
// Assumes: BLK_BYTES is a power-of-two multiple of SECT_BYTES; BCNT_W > LEN_W.
module dsp_pkt_pos #(
    parameter int LBA_W      = 28,
    parameter int BCNT_W     = 24,
    parameter int LEN_W      = 16,
    parameter int SECT_BYTES = 512,
    parameter int BLK_BYTES  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [LBA_W-1:0]  init_blk,
    input  logic [BCNT_W-1:0] init_bytes,
    input  logic              step,
    input  logic [LEN_W-1:0]  step_bytes,
    output logic [LBA_W-1:0]  sector_nx,
    output logic              done_nx
);
    localparam int S_SH  = $clog2(SECT_BYTES);
    localparam int B_SH  = $clog2(BLK_BYTES);
    localparam int R_SH  = B_SH - S_SH;
    localparam int BLK_W = LBA_W - R_SH;

    logic [BLK_W-1:0]         blk_q;
    logic [B_SH-1:0]          off_q;
    logic signed [BCNT_W:0]   rem_q;
    logic [LEN_W:0]           off_sum;
    logic [BLK_W-1:0]         blk_nx;
    logic [B_SH-1:0]          off_nx;
    logic signed [BCNT_W:0]   step_s;
    logic signed [BCNT_W:0]   rem_nx;

    // Carry the offset into the block address and derive the medium sector.
    always_comb begin
        off_sum   = (LEN_W+1)'(off_q) + (LEN_W+1)'(step_bytes);
        blk_nx    = blk_q + BLK_W'(off_sum >> B_SH);
        off_nx    = off_sum[B_SH-1:0];
        sector_nx = (LBA_W'(blk_nx) << R_SH) + LBA_W'(off_nx >> S_SH);
        step_s    = $signed((BCNT_W+1)'(step_bytes));
        rem_nx    = rem_q - step_s;
        done_nx   = rem_nx[BCNT_W] || (rem_nx == '0);
    end

    // Hold block, offset and remaining bytes; load at command start, advance per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
            off_q <= '0;
            rem_q <= '0;
        end else if (init) begin
            blk_q <= BLK_W'(init_blk);
            off_q <= '0;
            rem_q <= $signed((BCNT_W+1)'(init_bytes));
        end else if (step) begin
            blk_q <= blk_nx;
            off_q <= off_nx;
            rem_q <= rem_nx;
        end
    end

    // R8
    rem_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init) |=> (rem_q <= $past(rem_q)));

    // R7
    blk_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && step_bytes >= LEN_W'(BLK_BYTES)) |=> (blk_q != $past(blk_q)));
endmodule

// File: rtl/dsp_desc.sv
// Descriptor holder: address and length of the current scatter-gather entry.
// Issuing a request consumes the whole length: the address moves past it, the length becomes 0.
// Assumes: load and issue never arrive in the same cycle.
module dsp_desc #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              issue,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  len_q
);
    // Capture a new descriptor or drain the current one on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            len_q  <= load_len;
        end else if (issue) begin
            addr_q <= addr_q + ADDR_W'(len_q);
            len_q  <= '0;
        end
    end

    // R6
    desc_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load) |=> (len_q == '0));

    // R6
    desc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load) |=> (addr_q == $past(addr_q) + ADDR_W'($past(len_q))));
endmodule

// File: rtl/dma_sector_tracker.sv
// DMA sector progress tracker (top). It sequences the passes of each descriptor,
// picks the disk-mode or packet-mode position keeper, and drives the request,
// interrupt, status and DMA-end outputs. All outputs are registered.
// Assumes: chunk_done and chunk_err are given only while a request is outstanding.
module dma_sector_tracker #(
    parameter int LBA_W      = 28,
    parameter int SCNT_W     = 16,
    parameter int BCNT_W     = 24,
    parameter int LEN_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int SECT_BYTES = 512,
    parameter int BLK_BYTES  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_packet,
    input  logic              cmd_write,
    input  logic [LBA_W-1:0]  cmd_lba,
    input  logic [BCNT_W-1:0] cmd_count,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              chunk_done,
    input  logic              chunk_err,
    input  logic              media_absent,
    output logic              req_valid,
    output logic [LBA_W-1:0]  req_sector,
    output logic [LEN_W-1:0]  req_len,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    output logic              irq,
    output logic [2:0]        status,
    output logic [1:0]        err_kind,
    output logic              dma_end
);
    import dsp_pkg::*;

    trk_state_e        st_q;
    logic              pkt_q;
    logic              wr_q;
    logic              cmpl_q;
    logic [LEN_W-1:0]  last_len_q;
    logic              start_ok;
    logic              dsc_load;
    logic              dsc_issue;
    logic [ADDR_W-1:0] dsc_addr;
    logic [LEN_W-1:0]  dsc_len;
    logic              in_pass;
    logic              refuse;
    logic              dsk_step;
    logic              pkt_step;
    logic [LBA_W-1:0]  dsk_sec_nx;
    logic              dsk_zero_nx;
    logic [LBA_W-1:0]  pkt_sec_nx;
    logic              pkt_done_nx;
    logic [LBA_W-1:0]  sec_nx;
    logic              fin_nx;
    logic              req_valid_q;
    logic [LBA_W-1:0]  req_sector_q;
    logic [LEN_W-1:0]  req_len_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_write_q;
    logic              irq_q;
    logic [2:0]        status_q;
    err_kind_e         errk_q;
    logic              dma_end_q;

    // Decode pass-level control from the state and the inputs.
    always_comb begin
        start_ok  = cmd_start && (st_q == ST_IDLE || st_q == ST_WAITD);
        dsc_load  = (st_q == ST_WAITD) && desc_load && !cmd_start;
        in_pass   = (st_q == ST_PASS);
        refuse    = pkt_q && media_absent;
        dsc_issue = in_pass && (dsc_len != '0) && !refuse;
        dsk_step  = in_pass && !pkt_q;
        pkt_step  = in_pass && pkt_q;
        sec_nx    = pkt_q ? pkt_sec_nx : dsk_sec_nx;
        fin_nx    = pkt_q ? pkt_done_nx : dsk_zero_nx;
    end

    dsp_disk_pos #(
        .LBA_W(LBA_W), .CNT_W(SCNT_W), .LEN_W(LEN_W), .SECT_BYTES(SECT_BYTES)
    ) u_disk (
        .clk(clk), .rst_n(rst_n),
        .init(start_ok), .init_lba(cmd_lba), .init_cnt(SCNT_W'(cmd_count)),
        .step(dsk_step), .step_bytes(last_len_q),
        .lba_nx(dsk_sec_nx), .zero_nx(dsk_zero_nx)
    );

    dsp_pkt_pos #(
        .LBA_W(LBA_W), .BCNT_W(BCNT_W), .LEN_W(LEN_W),
        .SECT_BYTES(SECT_BYTES), .BLK_BYTES(BLK_BYTES)
    ) u_pkt (
        .clk(clk), .rst_n(rst_n),
        .init(start_ok), .init_blk(cmd_lba), .init_bytes(cmd_count),
        .step(pkt_step), .step_bytes(last_len_q),
        .sector_nx(pkt_sec_nx), .done_nx(pkt_done_nx)
    );

    dsp_desc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_desc (
        .clk(clk), .rst_n(rst_n),
        .load(dsc_load), .load_addr(desc_addr), .load_len(desc_len),
        .issue(dsc_issue),
        .addr_q(dsc_addr), .len_q(dsc_len)
    );

    // Command sequencer: start, descriptor pass, outstanding request, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            pkt_q        <= 1'b0;
            wr_q         <= 1'b0;
            cmpl_q       <= 1'b0;
            last_len_q   <= '0;
            req_valid_q  <= 1'b0;
            req_sector_q <= '0;
            req_len_q    <= '0;
            req_addr_q   <= '0;
            req_write_q  <= 1'b0;
            irq_q        <= 1'b0;
            status_q     <= STAT_RESET;
            errk_q       <= ERK_NONE;
            dma_end_q    <= 1'b0;
        end else begin
            req_valid_q <= 1'b0;
            irq_q       <= 1'b0;
            dma_end_q   <= 1'b0;
            unique case (st_q)
                ST_IDLE, ST_WAITD: begin
                    if (start_ok) begin
                        st_q     <= ST_WAITD;
                        pkt_q    <= cmd_packet;
                        wr_q     <= cmd_write && !cmd_packet;
                        cmpl_q   <= 1'b0;
                        status_q <= STAT_BUSY;
                        errk_q   <= ERK_NONE;
                    end else if (dsc_load) begin
                        st_q       <= ST_PASS;
                        last_len_q <= '0;
                    end
                end
                ST_PASS: begin
                    if (fin_nx && !cmpl_q) begin
                        irq_q    <= 1'b1;
                        status_q <= STAT_DONE;
                        cmpl_q   <= 1'b1;
                    end
                    if (dsc_len == '0) begin
                        dma_end_q <= 1'b1;
                        st_q      <= ST_WAITD;
                    end else if (refuse) begin
                        dma_end_q <= 1'b1;
                        status_q  <= STAT_FAIL;
                        errk_q    <= ERK_NOMED;
                        st_q      <= ST_IDLE;
                    end else begin
                        req_valid_q  <= 1'b1;
                        req_sector_q <= sec_nx;
                        req_len_q    <= dsc_len;
                        req_addr_q   <= dsc_addr;
                        req_write_q  <= wr_q;
                        last_len_q   <= dsc_len;
                        st_q         <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (chunk_err) begin
                        dma_end_q <= 1'b1;
                        status_q  <= STAT_FAIL;
                        errk_q    <= pkt_q ? ERK_IO : ERK_DMA;
                        st_q      <= ST_IDLE;
                    end else if (chunk_done) begin
                        st_q <= ST_PASS;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the ports from the registered copies.
    always_comb begin
        req_valid  = req_valid_q;
        req_sector = req_sector_q;
        req_len    = req_len_q;
        req_addr   = req_addr_q;
        req_write  = req_write_q;
        irq        = irq_q;
        status     = status_q;
        err_kind   = errk_q;
        dma_end    = dma_end_q;
    end

    // R5
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_q && dma_end_q));

    // R6
    req_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_q |-> (req_len_q != '0));

    // R4
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> status_q[0]);

    // R9
    err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[2]) |-> dma_end_q);

    // R11
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY || st_q == ST_PASS) |=> $stable(wr_q));

    // R11
    pkt_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_q && pkt_q) |-> !req_write_q);
endmodule

// File: tb/sim_dma_sector_tracker.sv
`timescale 1ns/1ps
module sim_dma_sector_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_packet = 1'b0;
    logic        cmd_write = 1'b0;
    logic [27:0] cmd_lba = '0;
    logic [23:0] cmd_count = '0;
    logic        desc_load = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [15:0] desc_len = '0;
    logic        chunk_done = 1'b0;
    logic        chunk_err = 1'b0;
    logic        media_absent = 1'b0;
    logic        req_valid;
    logic [27:0] req_sector;
    logic [15:0] req_len;
    logic [31:0] req_addr;
    logic        req_write;
    logic        irq;
    logic [2:0]  status;
    logic [1:0]  err_kind;
    logic        dma_end;

    int n_chk = 0;
    int n_err = 0;

    // Bench model of the block's observable state
    bit          m_active, m_pkt, m_wr, m_cmpl;
    logic [27:0] m_sec;
    int          m_cnt;
    logic [25:0] m_blk;
    int          m_off, m_rem, m_len, m_errk;
    logic [2:0]  m_stat;

    always #2 clk = ~clk;

    dma_sector_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_packet(cmd_packet),
        .cmd_write(cmd_write), .cmd_lba(cmd_lba), .cmd_count(cmd_count),
        .desc_load(desc_load), .desc_addr(desc_addr), .desc_len(desc_len),
        .chunk_done(chunk_done), .chunk_err(chunk_err), .media_absent(media_absent),
        .req_valid(req_valid), .req_sector(req_sector), .req_len(req_len),
        .req_addr(req_addr), .req_write(req_write), .irq(irq), .status(status),
        .err_kind(err_kind), .dma_end(dma_end)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic logic [27:0] exp_sector();
        if (m_pkt) return ({2'b00, m_blk} << 2) + 28'(m_off >> 9);
        return m_sec;
    endfunction

    function automatic bit fin_now();
        if (m_pkt) return m_rem <= 0;
        return m_cnt == 0;
    endfunction

    // Completion check of one pass (R4)
    function automatic bit pass_irq();
        if (m_active && !m_cmpl && fin_now()) begin
            m_cmpl = 1'b1;
            m_stat = 3'b011;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic do_cmd(input bit pkt, input bit wr, input logic [27:0] lba, input int cnt);
        @(negedge clk);
        cmd_start = 1'b1; cmd_packet = pkt; cmd_write = wr;
        cmd_lba = lba; cmd_count = 24'(cnt);
        @(posedge clk); #1;
        cmd_start = 1'b0;
        m_active = 1'b1; m_pkt = pkt; m_wr = wr && !pkt; m_cmpl = 1'b0;
        m_sec = lba; m_cnt = cnt & 16'hFFFF; m_blk = lba[25:0]; m_off = 0;
        m_rem = cnt; m_stat = 3'b000; m_errk = 0;
        chk("R2 status", status, 0);
        chk("R2 err_kind", err_kind, 0);
    endtask

    task automatic do_desc(input logic [31:0] a, input int l, input bit med, output bit issued);
        bit irq_e;
        @(negedge clk);
        desc_load = 1'b1; desc_addr = a; desc_len = 16'(l); media_absent = med;
        @(posedge clk); #1;
        desc_load = 1'b0;
        @(posedge clk); #1;
        issued = 1'b0;
        irq_e = pass_irq();
        if (!m_active) begin
            chk("R9 idle ignores desc req", req_valid, 0);
            chk("R9 idle ignores desc end", dma_end, 0);
        end else if (l == 0) begin
            chk("R5 zero desc end", dma_end, 1);
            chk("R5 zero desc no req", req_valid, 0);
        end else if (m_pkt && med) begin
            m_stat = 3'b101; m_errk = 3; m_active = 1'b0;
            chk("R10 refuse no req", req_valid, 0);
            chk("R10 refuse end", dma_end, 1);
        end else begin
            issued = 1'b1; m_len = l;
            chk("R6 req_valid", req_valid, 1);
            chk("R7 R6 req_sector", req_sector, exp_sector());
            chk("R6 req_len", req_len, l);
            chk("R6 req_addr", req_addr, a);
            chk("R11 req_write", req_write, m_wr);
            chk("R6 no end", dma_end, 0);
        end
        chk("R4 irq on desc pass", irq, irq_e);
        chk("R4 status", status, m_stat);
        chk("R10 err_kind", err_kind, m_errk);
        media_absent = 1'b0;
    endtask

    task automatic do_done();
        bit irq_e;
        int n;
        @(negedge clk);
        chunk_done = 1'b1;
        @(posedge clk); #1;
        chunk_done = 1'b0;
        @(posedge clk); #1;
        if (m_pkt) begin
            m_rem = m_rem - m_len;
            m_off = m_off + m_len;
            m_blk = m_blk + 26'(m_off >> 11);
            m_off = m_off & 32'h7FF;
        end else begin
            n = (m_len + 511) >> 9;
            m_sec = m_sec + 28'(n);
            m_cnt = (m_cnt > n) ? m_cnt - n : 0;
        end
        irq_e = pass_irq();
        chk("R5 done end", dma_end, 1);
        chk("R5 done no req", req_valid, 0);
        chk("R4 R3 R8 irq on done", irq, irq_e);
        chk("R4 status after done", status, m_stat);
    endtask

    task automatic do_err();
        @(negedge clk);
        chunk_err = 1'b1;
        @(posedge clk); #1;
        chunk_err = 1'b0;
        m_stat = 3'b101; m_errk = m_pkt ? 2 : 1; m_active = 1'b0;
        chk("R9 err end", dma_end, 1);
        chk("R9 err status", status, m_stat);
        chk("R9 err kind", err_kind, m_errk);
        chk("R9 err no irq", irq, 0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        bit iss;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 status", status, 1);
        chk("R1 err_kind", err_kind, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma_end", dma_end, 0);

        // Disk: exact sector then one byte over (R3), direction held (R11)
        do_cmd(1'b0, 1'b1, 28'h0000100, 4);
        cmd_write = 1'b0;
        do_desc(32'h1000, 512, 1'b0, iss);   do_done();
        do_desc(32'h2000, 513, 1'b0, iss);   do_done();
        do_desc(32'h3000, 0, 1'b0, iss);
        do_desc(32'h4000, 2000, 1'b0, iss);  do_done();   // saturates, irq once
        do_desc(32'h5000, 100, 1'b0, iss);   do_done();   // no second irq

        // Zero-count disk command completes on first pass (R4)
        do_cmd(1'b0, 1'b0, 28'h0FFFFFF, 0);
        do_desc(32'h6000, 0, 1'b0, iss);

        // Packet: offset carry into block (R7, R8)
        do_cmd(1'b1, 1'b1, 28'd5, 5000);
        do_desc(32'h7000, 700, 1'b0, iss);   do_done();
        do_desc(32'h8000, 1500, 1'b0, iss);  do_done();
        do_desc(32'h9000, 4096, 1'b0, iss);  do_done();
        do_desc(32'hA000, 10, 1'b0, iss);    do_done();

        // Medium absent (R10), then idle ignores descriptors (R9)
        do_cmd(1'b1, 1'b0, 28'd9, 300);
        do_desc(32'hB000, 64, 1'b1, iss);
        do_desc(32'hC000, 64, 1'b0, iss);

        // Chunk errors in both modes (R9)
        do_cmd(1'b0, 1'b1, 28'd77, 10);
        do_desc(32'hD000, 1024, 1'b0, iss);  do_err();
        do_desc(32'hE000, 64, 1'b0, iss);
        do_cmd(1'b1, 1'b0, 28'd3, 9000);
        do_desc(32'hF000, 1024, 1'b0, iss);  do_err();

        // Random mix
        for (int c = 0; c < 60; c++) begin
            bit pk;
            pk = 1'($urandom % 2);
            do_cmd(pk, 1'($urandom % 2), 28'($urandom),
                   pk ? int'($urandom % 20000) : int'($urandom % 25));
            for (int d = 0; d < 6; d++) begin
                int ln;
                bit md;
                if (!m_active) break;
                cmd_write = 1'($urandom % 2);
                ln = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 6000);
                md = pk && ($urandom % 10 == 0);
                do_desc($urandom, ln, md, iss);
                if (iss) begin
                    if ($urandom % 12 == 0) do_err();
                    else do_done();
                end
            end
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule